// File: doc/BRIEF.md
# Sub-second prescaler with phase shift

This block holds the sub-second part of a real-time clock. A 15-bit down counter is decremented on every prescaler enable pulse. When it runs out it reloads from a programmable divider value and sends a one-second increment toward a calendar that sits outside the block. Software trims the phase of the clock with a single command word. The low field of the word is a value added to the counter, which lengthens the current second. A flag in the top bit adds one whole second to the calendar in the same step. Together the two fields advance the clock by a fraction of a second.

A command is held pending until the next prescaler enable pulse. The counter and the calendar increment are then updated together, so the shift takes effect in one step. While a command is pending, further commands are dropped. An accepted command clears a synchronised flag. That flag comes back a fixed number of enable pulses after the shift has been applied, which models the latency of the shadow copy of the time.

Top module: `rtc_subsec_shift`

## Requirements
- R1: After reset, `ss_count` is 0, `shift_pend` is 0, `sec_inc` is 0 and `sync_ok` is 0. No command is held.
- R2: `cmd_rdata` always reads as zero, whatever has been written.
- R3: On each cycle with `prescale_en` high and no shift applied, a nonzero `ss_count` decrements by one. A zero `ss_count` reloads `prediv_s`, and `sec_inc` reads 1 in the following cycle only.
- R4: A `cmd_wr` while `shift_pend` is 0 is accepted, and `shift_pend` reads 1 from the next cycle. The subtract value is taken from `cmd_wdata[14:0]` and the add-second flag from `cmd_wdata[31]`. Bits 30:15 have no effect.
- R5: A `cmd_wr` while `shift_pend` is 1 is ignored entirely. The shift that is later applied is the one accepted first.
- R6: On the first `prescale_en` pulse after acceptance, the counter becomes the value R3 would give plus the subtract value, and `shift_pend` returns to 0 in the same update.
- R7: If the add-second flag is set, `sec_inc` in that update equals 1 plus the normal underflow increment, so it reads 2 when the counter also wrapped. `sec_inc` is 0 in every cycle that does not follow an enable pulse.
- R8: The addition in R6 is done one bit wider and saturates at 0x7FFF. A count above `prediv_s` simply counts down without any extra increment.
- R9: An accepted write drops `sync_ok` to 0 from the next cycle. `sync_ok` stays 0 while the shift is pending and returns to 1 on the second enable pulse after the pulse that applied the shift. After reset it likewise becomes 1 on the second enable pulse.
- R10: In a cycle without `prescale_en`, `ss_count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prescale_en | input | 1 | One-cycle pulse from the asynchronous prescaler |
| prediv_s | input | 15 | Reload value of the sub-second counter |
| cmd_wr | input | 1 | Shift command write strobe |
| cmd_wdata | input | 32 | Shift command word |
| cmd_rdata | output | 32 | Command readback, always zero |
| ss_count | output | 15 | Sub-second down counter |
| sec_inc | output | 2 | Seconds to add to the calendar this cycle |
| shift_pend | output | 1 | Shift accepted and not yet applied |
| sync_ok | output | 1 | Shadowed time reflects the counter |

## Verification
The bench keeps the default settling latency of two pulses and drives the divider at 3 and then at 7. These small periods let every counter phase before the shift, including the zero that wraps, be reached in a few pulses. The sweep covers every phase with subtract values of 0, 1, the divider, the divider plus one, a mid-range value and the saturating maximum, each with and without the add-second flag. Each case also sends a second command while the first is pending, sets the reserved bits, and runs a few pulses past the shift so that the settling of the synchronised flag is visible.

// File: rtl/rtc_shift_pkg.sv
package rtc_shift_pkg;
   parameter int SS_W    = 15;
   parameter int CMD_W   = 32;
   parameter int ADD_POS = 31;

   typedef struct packed {
      logic            add_sec;
      logic [SS_W-1:0] sub_val;
   } shift_cmd_t;

   function automatic logic [SS_W-1:0] sat_sum(input logic [SS_W-1:0] a,
                                               input logic [SS_W-1:0] b);
      logic [SS_W:0] wide;
      wide = {1'b0, a} + {1'b0, b};
      return wide[SS_W] ? {SS_W{1'b1}} : wide[SS_W-1:0];
   endfunction
endpackage

// File: rtl/rtc_shift_cmd.sv
module rtc_shift_cmd
   import rtc_shift_pkg::*;
#(
   parameter int W   = SS_W,
   parameter int CW  = CMD_W,
   parameter int AP  = ADD_POS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   input  logic          apply,
   output logic          accept,
   output logic          pend,
   output shift_cmd_t    cmd
);
   generate
      if (AP < W || AP >= CW) begin : g_bad_pos
         $error("add-second bit must sit above the subtract field");
      end
      if (W != SS_W) begin : g_bad_w
         $error("field width must match package width");
      end
   endgenerate

   assign accept = wr & ~pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cmd  <= '0;
      end else if (accept) begin
         pend        <= 1'b1;
         cmd.add_sec <= wdata[AP];
         cmd.sub_val <= wdata[W-1:0];
      end else if (apply) begin
         pend <= 1'b0;
      end
   end

   // R5: a pending command is frozen until applied
   a_r5_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !apply |=> pend && $stable(cmd));
   // R6: applying always retires the command
   a_r6_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> !pend);
   // R4: an accepted write always raises pending
   a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !pend |=> pend);
endmodule

// File: rtl/rtc_subsec_cnt.sv
module rtc_subsec_cnt
   import rtc_shift_pkg::*;
#(
   parameter int W = SS_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] prediv,
   input  logic         apply,
   input  shift_cmd_t   cmd,
   output logic [W-1:0] cnt,
   output logic [1:0]   inc
);
   logic         wrap;
   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic [1:0]   nxt_inc;

   always_comb begin
      wrap    = (cnt == '0);
      base    = wrap ? prediv : cnt - 1'b1;
      nxt     = apply ? sat_sum(base, cmd.sub_val) : base;
      nxt_inc = {1'b0, wrap} + {1'b0, apply & cmd.add_sec};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         inc <= '0;
      end else begin
         inc <= en ? nxt_inc : 2'd0;
         if (en) cnt <= nxt;
      end
   end

   // R10: no enable, no movement
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt));
   // R3: plain wrap reloads the divider
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      en && !apply && cnt == '0 |=> cnt == $past(prediv) && inc == 2'd1);
   // R7: no calendar increment without a pulse
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> inc == 2'd0);
   // R8: a shift never leaves the counter below the plain result
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      en && apply && cnt != '0 |=> cnt >= $past(cnt) - 1'b1);
endmodule

// File: rtl/rtc_sync_flag.sv
module rtc_sync_flag #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic accept,
   input  logic apply,
   output logic ok
);
   generate
      if (LAT < 0) begin : g_bad_lat
         $error("settling latency must not be negative");
      end
      if (LAT == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ok <= 1'b1;
            else if (accept) ok <= 1'b0;
            else if (apply)  ok <= 1'b1;
         end
      end else begin : g_delayed
         localparam int CW = $clog2(LAT + 1);
         localparam logic [CW-1:0] LOAD = CW'(LAT);
         logic [CW-1:0] wt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ok <= 1'b0;
               wt <= LOAD;
            end else if (accept) begin
               ok <= 1'b0;
               wt <= '0;
            end else if (apply) begin
               wt <= LOAD;
            end else if (en && wt != '0) begin
               wt <= wt - 1'b1;
               if (wt == CW'(1)) ok <= 1'b1;
            end
         end
         // R9: the flag only rises on an enable pulse
         a_r9_rise_on_en: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ok) |-> $past(en));
      end
   endgenerate
endmodule

// File: rtl/rtc_subsec_shift.sv
module rtc_subsec_shift
   import rtc_shift_pkg::*;
#(
   parameter int SYNC_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prescale_en,
   input  logic [SS_W-1:0]  prediv_s,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   output logic [CMD_W-1:0] cmd_rdata,
   output logic [SS_W-1:0]  ss_count,
   output logic [1:0]       sec_inc,
   output logic             shift_pend,
   output logic             sync_ok
);
   logic       accept;
   logic       apply;
   shift_cmd_t cmd;

   assign apply     = prescale_en & shift_pend;
   assign cmd_rdata = '0;

   rtc_shift_cmd #(.W(SS_W), .CW(CMD_W), .AP(ADD_POS)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_wdata),
      .apply(apply), .accept(accept), .pend(shift_pend), .cmd(cmd)
   );

   rtc_subsec_cnt #(.W(SS_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(prescale_en), .prediv(prediv_s),
      .apply(apply), .cmd(cmd), .cnt(ss_count), .inc(sec_inc)
   );

   rtc_sync_flag #(.LAT(SYNC_LAT)) u_sync (
      .clk(clk), .rst_n(rst_n), .en(prescale_en), .accept(accept),
      .apply(apply), .ok(sync_ok)
   );

   // R9: the time is never reported synchronised while a shift waits
   a_r9_low_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pend |-> !sync_ok);
endmodule

// File: tb/tb_rtc_subsec_shift.sv
module tb_rtc_subsec_shift;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prescale_en = 1'b0;
   logic [14:0] prediv_s = 15'd7;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic [14:0] ss_count;
   logic [1:0]  sec_inc;
   logic        shift_pend;
   logic        sync_ok;

   int checks = 0;
   int failures = 0;

   // bench model state
   int e_cnt, e_inc, e_pend, e_add, e_sub, e_sync, e_wait, e_p;

   rtc_subsec_shift dut (
      .clk(clk), .rst_n(rst_n), .prescale_en(prescale_en), .prediv_s(prediv_s),
      .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .ss_count(ss_count), .sec_inc(sec_inc), .shift_pend(shift_pend),
      .sync_ok(sync_ok)
   );

   always #4 clk = ~clk;

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string cnt_tag, input string inc_tag,
                          input string pend_tag);
      chk(int'(ss_count), e_cnt, cnt_tag);
      chk(int'(sec_inc), e_inc, inc_tag);
      chk(int'(shift_pend), e_pend, pend_tag);
      chk(int'(sync_ok), e_sync, "R9");
      chk(int'(cmd_rdata), 0, "R2");
   endtask

   task automatic do_reset(input int p);
      @(negedge clk);
      rst_n = 1'b0;
      prediv_s = 15'(p);
      prescale_en = 1'b0;
      cmd_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      e_p = p; e_cnt = 0; e_inc = 0; e_pend = 0; e_add = 0; e_sub = 0;
      e_sync = 0; e_wait = 2;
      chk_all("R1", "R1", "R1");
   endtask

   task automatic pulse();
      string ct, it;
      int base, sum;
      prescale_en = 1'b1;
      @(negedge clk);
      prescale_en = 1'b0;
      base = (e_cnt == 0) ? e_p : e_cnt - 1;
      e_inc = (e_cnt == 0) ? 1 : 0;
      ct = "R3"; it = "R3";
      if (e_pend == 1) begin
         sum = base + e_sub;
         ct = (sum > 32767) ? "R8" : "R6";
         if (sum > 32767) sum = 32767;
         e_cnt = sum;
         if (e_add == 1) begin
            e_inc = e_inc + 1;
            it = "R7";
         end
         e_pend = 0;
         e_wait = 2;
      end else begin
         e_cnt = base;
         if (e_wait > 0) begin
            e_wait--;
            if (e_wait == 0) e_sync = 1;
         end
      end
      chk_all(ct, it, "R6");
   endtask

   task automatic write(input int add, input int sub);
      string pt;
      cmd_wr = 1'b1;
      cmd_wdata = {add[0], 16'hA5C3, sub[14:0]};
      @(negedge clk);
      cmd_wr = 1'b0;
      cmd_wdata = '1;
      e_inc = 0;
      if (e_pend == 0) begin
         e_pend = 1; e_add = add; e_sub = sub; e_sync = 0; e_wait = 0;
         pt = "R4";
      end else begin
         pt = "R5";
      end
      chk_all("R10", "R7", pt);
   endtask

   task automatic idle();
      @(negedge clk);
      e_inc = 0;
      chk_all("R10", "R7", "R5");
   endtask

   initial begin
      #1500000;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int subs[6];
      do_reset(7);
      idle();
      for (int k = 0; k < 10; k++) pulse();
      for (int pi = 0; pi < 2; pi++) begin
         int p = (pi == 0) ? 3 : 7;
         subs[0] = 0; subs[1] = 1; subs[2] = p; subs[3] = p + 1;
         subs[4] = 16384; subs[5] = 32767;
         for (int add = 0; add < 2; add++) begin
            for (int si = 0; si < 6; si++) begin
               for (int ph = 0; ph <= p + 1; ph++) begin
                  do_reset(p);
                  for (int k = 0; k < ph; k++) pulse();
                  write(add, subs[si]);
                  idle();
                  write(1 - add, 32767 - subs[si]);
                  pulse();
                  idle();
                  for (int k = 0; k < 3; k++) pulse();
               end
            end
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule